// File: doc/BRIEF.md
# Packed Pixel Line Buffer Writer

This block builds one scanline of indexed pixels ahead of display time. The fetch side delivers 16-bit words from video memory. Each word packs four 4-bit colour indices and comes with a 4-bit palette-row select. Every index picks one of the sixteen colours in that row. The block stores each word once in a small staging memory. A sequencer then unpacks the staged words and writes exactly one pixel per clock into a line memory. Each line-memory entry is 8 bits: the palette row in the upper nibble and the colour index in the lower nibble.

Both memories take at most one write per cycle, so each one fits a plain single-write-port RAM. The display side reads the finished line through a separate port with one cycle of registered latency. A line-start pulse begins a new line. A line-done pulse reports that the last visible pixel has been written. A fetch of 41 eight-pixel tiles overruns a 320-pixel line, and the pixels past the line end are dropped.

Top module: `packed_line_writer`

## Requirements
- R1: A word is taken on a cycle with `in_valid` and `in_ready` both high. The staging memory holds up to `STAGE_DEPTH` words. `in_ready` is low while it is full, so no staged word is lost or overwritten before it has been unpacked.
- R2: The pixel in bits [15:12] of a word is written at the current x, then bits [11:8], [7:4] and [3:0] at x+1, x+2 and x+3. Each stored entry is {row[3:0], index[3:0]}.
- R3: The line memory receives at most one pixel per clock. While staged words are waiting, pixels follow each other with no idle cycle, including across word boundaries. A word reaching an idle sequencer writes its first pixel on the cycle after it is popped.
- R4: A `line_start` pulse empties the staging memory, abandons the word being unpacked, and sets x back to 0. `in_ready` is low during that cycle and no word is taken. No pixel is written in that cycle, and `line_done` is low in the cycle after it.
- R5: Pixels whose x is `LINE_W` or more are dropped and leave the line memory unchanged. x stops at `LINE_W`.
- R6: `line_done` is high for exactly one cycle, the cycle after the pixel at x = `LINE_W`-1 is written. It does not rise again before the next `line_start`.
- R7: `rd_data` shows the entry at `rd_addr` one cycle after the address is presented, whatever the write side is doing. A read of the address being written in the same cycle returns the old entry. Any address of `LINE_W` or more reads as 0.
- R8: After reset the staging memory is empty, `in_ready` is high and `line_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Begin a new scanline (one-cycle pulse) |
| in_valid | input | 1 | Fetch side offers a word |
| in_ready | output | 1 | Block accepts the offered word this cycle |
| in_word | input | 16 | Four packed 4-bit colour indices, first pixel in the top nibble |
| in_row | input | 4 | Palette-row select for all four pixels of the word |
| rd_addr | input | $clog2(LINE_W) | Display-side read address |
| rd_data | output | 8 | Registered entry {row, index} read from the line memory |
| line_done | output | 1 | One-cycle pulse after the last visible pixel is written |

## Verification
The unpacking path runs under three kinds of stream. A full-rate stream fills the staging memory, which shows that backpressure works and that consecutive words are unpacked with no gap. A sparse stream at about one word per four cycles leaves the sequencer idle between words, which exposes any error in the load-after-idle timing. An oversized 100-word fetch checks that writes past the line end are dropped and that `line_done` pulses only once. A second line is restarted while words are still staged, which separates a correct flush from stale pixels. Random and swept read addresses, including out-of-range addresses and reads of the address being written, compare the line memory entry by entry with the bench's own model.

// File: rtl/plw_pkg.sv
package plw_pkg;

    localparam int WORD_W        = 16;
    localparam int PIX_W         = 4;
    localparam int ROW_W         = 4;
    localparam int PIX_PER_WORD  = WORD_W / PIX_W;
    localparam int SLOT_W        = $clog2(PIX_PER_WORD);
    localparam int ENTRY_W       = ROW_W + PIX_W;

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [WORD_W-1:0] word;
    } stage_word_t;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [PIX_W-1:0] idx;
    } line_entry_t;

    // Slot 0 is the most significant nibble.
    function automatic logic [PIX_W-1:0] pick_pixel(input logic [WORD_W-1:0] w,
                                                    input logic [SLOT_W-1:0] s);
        return w[WORD_W-1-PIX_W*int'(s) -: PIX_W];
    endfunction

endpackage

// File: rtl/stage_buffer.sv
module stage_buffer
    import plw_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        push,
    input  stage_word_t push_data,
    input  logic        pop,
    output stage_word_t pop_data,
    output logic        empty,
    output logic        full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    stage_word_t      slots [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    // Storage: single write port, no reset, so it maps to RAM.
    always_ff @(posedge clk) begin
        if (push && !flush) slots[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign pop_data = slots[rp];
    assign empty    = (cnt == '0);
    assign full     = (cnt == CW'(DEPTH));

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    p_no_underflow_r1: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
    p_count_bound_r1: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(DEPTH));

endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
    import plw_pkg::*;
#(
    parameter int LINE_W = 320
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       src_empty,
    input  stage_word_t                src_data,
    output logic                       src_pop,
    output logic                       we,
    output logic [$clog2(LINE_W)-1:0]  waddr,
    output line_entry_t                wdata,
    output logic                       last_write
);
    localparam int AW = $clog2(LINE_W);
    localparam int XW = $clog2(LINE_W + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PIX_PER_WORD - 1);

    stage_word_t       cur;
    logic              busy;
    logic [SLOT_W-1:0] slot;
    logic [XW-1:0]     x;
    logic              in_line;

    assign in_line    = (x < XW'(LINE_W));
    assign src_pop    = !flush && !src_empty && (!busy || slot == LAST_SLOT);
    assign we         = busy && !flush && in_line;
    assign waddr      = x[AW-1:0];
    assign wdata      = '{row: cur.row, idx: pick_pixel(cur.word, slot)};
    assign last_write = we && (x == XW'(LINE_W - 1));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            busy <= 1'b0;
            slot <= '0;
            x    <= '0;
        end else begin
            if (busy) begin
                slot <= slot + 1'b1;
                if (in_line) x <= x + 1'b1;
            end
            if (src_pop) begin
                busy <= 1'b1;
                slot <= '0;
            end else if (busy && slot == LAST_SLOT) begin
                busy <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (src_pop) cur <= src_data;
    end

    p_x_step_r3: assert property (@(posedge clk) disable iff (rst)
        we |=> (x == $past(x) + 1'b1));
    p_x_sat_r5: assert property (@(posedge clk) disable iff (rst) x <= XW'(LINE_W));
    p_flush_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        flush |=> (x == '0 && !busy));

endmodule

// File: rtl/line_store.sv
module line_store
    import plw_pkg::*;
#(
    parameter int LINE_W = 320
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [$clog2(LINE_W)-1:0]  waddr,
    input  line_entry_t                wdata,
    input  logic [$clog2(LINE_W)-1:0]  raddr,
    output line_entry_t                rdata
);
    line_entry_t mem [LINE_W];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (raddr < LINE_W) rdata <= mem[raddr];
        else                rdata <= '0;
    end

endmodule

// File: rtl/packed_line_writer.sv
module packed_line_writer
    import plw_pkg::*;
#(
    parameter int LINE_W      = 320,
    parameter int STAGE_DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       line_start,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [15:0]                in_word,
    input  logic [3:0]                 in_row,
    input  logic [$clog2(LINE_W)-1:0]  rd_addr,
    output logic [7:0]                 rd_data,
    output logic                       line_done
);
    localparam int AW = $clog2(LINE_W);

    stage_word_t   st_in, st_out;
    logic          st_empty, st_full, st_pop, push;
    logic          lb_we, last_write;
    logic [AW-1:0] lb_waddr;
    line_entry_t   lb_wdata, lb_rdata;

    assign in_ready = !st_full && !line_start;
    assign push     = in_valid && in_ready;
    assign st_in    = '{row: in_row, word: in_word};

    stage_buffer #(.DEPTH(STAGE_DEPTH)) u_stage (
        .clk(clk), .rst(rst), .flush(line_start),
        .push(push), .push_data(st_in),
        .pop(st_pop), .pop_data(st_out),
        .empty(st_empty), .full(st_full)
    );

    pixel_serializer #(.LINE_W(LINE_W)) u_ser (
        .clk(clk), .rst(rst), .flush(line_start),
        .src_empty(st_empty), .src_data(st_out), .src_pop(st_pop),
        .we(lb_we), .waddr(lb_waddr), .wdata(lb_wdata),
        .last_write(last_write)
    );

    line_store #(.LINE_W(LINE_W)) u_line (
        .clk(clk), .we(lb_we), .waddr(lb_waddr), .wdata(lb_wdata),
        .raddr(rd_addr), .rdata(lb_rdata)
    );

    assign rd_data = lb_rdata;

    always_ff @(posedge clk) begin
        if (rst) line_done <= 1'b0;
        else     line_done <= last_write;
    end

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst) line_done |=> !line_done);
    p_start_clears_r4: assert property (@(posedge clk) disable iff (rst) line_start |=> !line_done);

endmodule

// File: tb/sim_packed_line_writer.sv
`timescale 1ns/1ps
module sim_packed_line_writer;
    localparam int LW  = 320;
    localparam int SD  = 4;
    localparam int RAW = $clog2(LW);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           line_start = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [15:0]    in_word = '0;
    logic [3:0]     in_row = '0;
    logic [RAW-1:0] rd_addr = '0;
    logic [7:0]     rd_data;
    logic           line_done;

    always #2.5 clk = ~clk;

    packed_line_writer #(.LINE_W(LW), .STAGE_DEPTH(SD)) u0 (
        .clk(clk), .rst(rst), .line_start(line_start),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_row(in_row),
        .rd_addr(rd_addr), .rd_data(rd_data), .line_done(line_done)
    );

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    logic [19:0] mq [$];
    logic [7:0]  mpix [$];
    int          mx = 0;
    logic [7:0]  mmem [LW];
    bit          mknown [LW];
    logic [7:0]  exp_rd = '0;
    bit          exp_rd_known = 0;
    bit          exp_done = 0;
    int          words_left = 0;
    bit          need_new = 1;

    // Stimulus controls
    int  pct = 100;
    bit  sweep = 0;
    int  sweep_idx = 0;
    bit  ls_req = 0;
    int  done_count = 0;
    int  bp_cycles = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        logic [7:0]  rn;
        bit          rk;
        bit          dn;
        int          qs;
        logic [19:0] w;
        logic [7:0]  p;
        if (rd_addr < LW) begin rn = mmem[rd_addr]; rk = mknown[rd_addr]; end
        else begin rn = '0; rk = 1; end
        dn = 0;
        if (rst || line_start) begin
            mq.delete();
            mpix.delete();
            mx = 0;
        end else begin
            qs = mq.size();
            if (mpix.size() > 0) begin
                p = mpix.pop_front();
                if (mx < LW) begin
                    mmem[mx] = p;
                    mknown[mx] = 1;
                    if (mx == LW - 1) dn = 1;
                    mx++;
                end
            end
            if (mpix.size() == 0 && qs > 0) begin
                w = mq.pop_front();
                for (int k = 0; k < 4; k++)
                    mpix.push_back({w[19:16], w[15-4*k -: 4]});
            end
            if (in_valid && qs < SD) begin
                mq.push_back({in_row, in_word});
                words_left--;
                need_new = 1;
            end
        end
        exp_done = dn;
        exp_rd = rn;
        exp_rd_known = rk;
    end

    task automatic cycle();
        bit er;
        @(negedge clk);
        if (!rst) begin
            check(line_done === exp_done, "R6 R3", "line_done", int'(line_done), int'(exp_done));
            if (line_done) done_count++;
            if (exp_rd_known)
                check(rd_data === exp_rd, "R2 R7", "rd_data", int'(rd_data), int'(exp_rd));
        end
        line_start = ls_req;
        ls_req = 0;
        if (need_new) begin
            in_word = 16'($urandom);
            in_row  = 4'($urandom);
            need_new = 0;
        end
        in_valid = (words_left > 0) && !line_start && ($urandom_range(0, 99) < pct);
        if (sweep) begin
            rd_addr = RAW'(sweep_idx);
            sweep_idx++;
        end else begin
            rd_addr = RAW'($urandom);
        end
        #0.5;
        if (!rst) begin
            er = (mq.size() < SD) && !line_start;
            check(in_ready === er, line_start ? "R4" : "R1", "in_ready", int'(in_ready), int'(er));
            if (!in_ready && !line_start) bp_cycles++;
        end
    endtask

    task automatic run_line(input int nwords, input int rate);
        ls_req = 1;
        cycle();
        done_count = 0;
        words_left = nwords;
        pct = rate;
        while (words_left > 0 || mq.size() > 0 || mpix.size() > 0) cycle();
        repeat (3) cycle();
    endtask

    task automatic sweep_read();
        sweep = 1;
        sweep_idx = 0;
        repeat (1 << RAW) cycle();
        sweep = 0;
        repeat (2) cycle();
    endtask

    initial begin
        #(100000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) cycle();
        rst = 0;
        cycle();
        // R8: reset state
        check(in_ready === 1'b1, "R8", "in_ready after reset", int'(in_ready), 1);
        check(line_done === 1'b0, "R8", "line_done after reset", int'(line_done), 0);

        // R1 R2 R3: full-rate 41-tile fetch (82 words)
        bp_cycles = 0;
        run_line(82, 100);
        check(done_count == 1, "R6", "done pulses full rate", done_count, 1);
        check(bp_cycles > 0, "R1", "backpressure seen", bp_cycles, 1);
        sweep_read();   // R7 out-of-range reads included

        // R3: sparse stream, sequencer idles between words
        run_line(82, 25);
        check(done_count == 1, "R6", "done pulses sparse", done_count, 1);
        sweep_read();

        // R4: restart a line while words are staged
        ls_req = 1;
        cycle();
        words_left = 30;
        pct = 100;
        repeat (40) cycle();
        check(mq.size() > 0, "R4", "staging busy at restart", mq.size(), 1);
        words_left = 0;
        run_line(82, 100);
        check(done_count == 1, "R4", "done after restart", done_count, 1);
        sweep_read();

        // R5: oversized fetch, writes past the line end dropped
        run_line(100, 100);
        check(done_count == 1, "R5", "single done on overrun", done_count, 1);
        sweep_read();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule